// File: doc/BRIEF.md
# Page-Splitting Flash Program Engine

This block takes one program request (start address, byte count, and an address-width selector) and writes the matching byte stream to a serial NOR flash. It issues a sequence of page-program frames on a mode-0 SPI bus. Each frame stays inside one flash page, so a request that runs across page boundaries is cut into chunks.

Every chunk is a pair of chip-select frames:

- a write-enable frame holding a single opcode;
- a program frame holding the program opcode, the address and the chunk's data bytes.

When a program frame closes, the engine sets a busy code for an external status poller. It does not start the next chunk until the poller reports that the device has finished.

Data arrives on a byte stream with a valid/ready handshake. The engine pulls a byte only while it is sending the data part of a program frame, and stalls the stream at all other times. A request with a byte count of zero is acknowledged at once and produces no bus activity. A single-cycle done pulse marks the end of every request.

Top module: `flash_prog_engine`

## Requirements
- R1: A chunk holds min(remaining bytes, PAGE_BYTES - (address mod PAGE_BYTES)) data bytes (PAGE_BYTES = 256 by default), so no program frame crosses a page boundary.
- R2: Each chunk begins with a frame that contains only the byte 0x06, after which chip-select returns high.
- R3: The program frame begins with the byte 0x02 followed by the address, most significant byte first. With addr4_i = 1 at request time it carries address bits 31:0 as four bytes; with addr4_i = 0 it carries bits 23:0 as three bytes and drops bits 31:24.
- R4: The chunk's data bytes follow the address in the same frame, in stream order, and chip-select rises only after the last data bit.
- R5: busy_code_o becomes 1 in the cycle the program frame's chip-select rises, and returns to 0 one cycle after a poll_done_i pulse. Chip-select never falls while busy_code_o is non-zero.
- R6: The address advances by each chunk's length and chunks repeat until the requested length is used up. Exactly req_len_i stream bytes are consumed.
- R7: A request with req_len_i = 0 raises done_o in the cycle after acceptance, with no chip-select activity and no stream byte consumed.
- R8: wready_o is high only while chip-select is low and the command and address bytes of a program frame have been sent.
- R9: done_o is a single-cycle pulse, asserted in the cycle the final chunk's chip-select rises.
- R10: SPI mode 0: the clock idles low, bits go out most significant first, and mosi does not change while the clock is high. req_ready_o is high only while the engine is idle with chip-select high.
- R11: After reset, chip-select is high, the clock is low, busy_code_o is 0, done_o and wready_o are low, and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Program request valid |
| req_ready_o | output | 1 | Engine idle, request accepted |
| req_addr_i | input | ADDR_W | Start address |
| req_len_i | input | LEN_W | Byte count |
| addr4_i | input | 1 | 1 = four address bytes, 0 = three |
| wdata_i | input | 8 | Stream data byte |
| wvalid_i | input | 1 | Stream byte valid |
| wready_o | output | 1 | Stream byte taken |
| busy_code_o | output | 2 | Busy code for the status poller (1 = program in progress) |
| poll_done_i | input | 1 | Poller reports device finished |
| done_o | output | 1 | Request complete pulse |
| spi_sclk_o | output | 1 | SPI clock |
| spi_cs_no | output | 1 | SPI chip-select, active low |
| spi_mosi_o | output | 1 | SPI data out |

## Verification
The bench sweeps start offsets 0, 1, 200 and 255 within a page against lengths 1, 2, 255, 256, 257 and 300, and alternates the address width. A design with an off-by-one in the page-space arithmetic would show up at offset 255, where the first chunk is a single byte, and on the aligned 256-byte case, where one frame must hold the whole page. A design that dropped the fourth address byte, or kept the top byte in three-byte mode, would produce frames that differ from the bench's decoded expectation. Zero-length requests, a stream that stalls every fourth cycle, and a poller with varying latency check for extra bus traffic, for bytes taken outside the data phase, and for a chunk that starts before the busy code has cleared.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_WREN,
    ST_GAP,
    ST_CMD,
    ST_ADDR,
    ST_DATA
  } fpe_state_e;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [1:0] BUSY_NONE = 2'd0;
  localparam logic [1:0] BUSY_PROG = 2'd1;
endpackage

// File: rtl/fpe_spi_shifter.sv
module fpe_spi_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  output logic       active_o,
  output logic       done_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  logic       active_q, phase_q;
  logic [2:0] bit_q;
  logic [7:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      phase_q  <= 1'b0;
      bit_q    <= '0;
      sh_q     <= byte_i;
    end else if (active_q) begin
      if (!phase_q) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        if (bit_q == 3'd7) begin
          active_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 3'd1;
          sh_q  <= {sh_q[6:0], 1'b0};
        end
      end
    end
  end

  // low half drives the bit, high half lets the device sample it
  assign sclk_o   = active_q & phase_q;
  assign mosi_o   = sh_q[7];
  assign active_o = active_q;
  assign done_o   = active_q & phase_q & (bit_q == 3'd7);
endmodule

// File: rtl/fpe_chunk_calc.sv
module fpe_chunk_calc #(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned PAGE_BYTES = 256,
  localparam int unsigned PW        = $clog2(PAGE_BYTES)
) (
  input  logic [PW-1:0]    addr_lo_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic [PW:0]      chunk_o
);
  localparam int unsigned CW = (LEN_W > PW + 1) ? LEN_W : PW + 1;

  logic [CW-1:0] space, rem_ext;

  always_comb begin
    space   = CW'(PAGE_BYTES) - CW'(addr_lo_i);
    rem_ext = CW'(rem_i);
    chunk_o = (rem_ext < space) ? rem_ext[PW:0] : space[PW:0];
  end
endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
  import flash_prog_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned PAGE_BYTES = 256,
  parameter int unsigned CS_GAP     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              addr4_i,
  input  logic [7:0]        wdata_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        busy_code_o,
  input  logic              poll_done_i,
  output logic              done_o,
  output logic              spi_sclk_o,
  output logic              spi_cs_no,
  output logic              spi_mosi_o
);
  localparam int unsigned PW = $clog2(PAGE_BYTES);
  localparam int unsigned GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

  fpe_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [PW:0]       left_q, chunk_len;
  logic [1:0]        idx_q, busy_q;
  logic [GW-1:0]     gap_q;
  logic              a4_q, launched_q, cs_q, done_q;

  logic              tx_start, tx_done, tx_active, byte_state;
  logic [7:0]        tx_byte;
  logic [31:0]       a32;
  logic [7:0]        addr_byte [4];

  assign a32 = 32'(addr_q);
  for (genvar g = 0; g < 4; g++) begin : g_abyte
    assign addr_byte[g] = a32[8*g +: 8];
  end

  fpe_chunk_calc #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .addr_lo_i (addr_q[PW-1:0]),
    .rem_i     (rem_q),
    .chunk_o   (chunk_len)
  );

  always_comb begin
    unique case (st_q)
      ST_WREN: tx_byte = OP_WREN;
      ST_CMD:  tx_byte = OP_PROG;
      ST_ADDR: tx_byte = addr_byte[idx_q];
      ST_DATA: tx_byte = wdata_i;
      default: tx_byte = 8'h00;
    endcase
  end

  assign byte_state = (st_q == ST_WREN) || (st_q == ST_CMD) ||
                      (st_q == ST_ADDR) || (st_q == ST_DATA);
  assign tx_start   = byte_state && !launched_q && !tx_active &&
                      ((st_q != ST_DATA) || wvalid_i);
  assign wready_o   = (st_q == ST_DATA) && !launched_q && !tx_active;

  fpe_spi_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tx_start),
    .byte_i   (tx_byte),
    .active_o (tx_active),
    .done_o   (tx_done),
    .sclk_o   (spi_sclk_o),
    .mosi_o   (spi_mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      rem_q      <= '0;
      left_q     <= '0;
      idx_q      <= '0;
      gap_q      <= '0;
      a4_q       <= 1'b0;
      launched_q <= 1'b0;
      cs_q       <= 1'b1;
      busy_q     <= BUSY_NONE;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tx_start) launched_q <= 1'b1;
      if (tx_done)  launched_q <= 1'b0;
      if (poll_done_i && (busy_q != BUSY_NONE)) busy_q <= BUSY_NONE;

      unique case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (req_len_i == '0) begin
              done_q <= 1'b1;
            end else begin
              addr_q <= req_addr_i;
              rem_q  <= req_len_i;
              a4_q   <= addr4_i;
              st_q   <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (busy_q == BUSY_NONE) begin
            left_q <= chunk_len;
            cs_q   <= 1'b0;
            st_q   <= ST_WREN;
          end
        end
        ST_WREN: begin
          if (tx_done) begin
            cs_q  <= 1'b1;
            gap_q <= '0;
            st_q  <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_q == GW'(CS_GAP - 1)) begin
            cs_q  <= 1'b0;
            idx_q <= a4_q ? 2'd3 : 2'd2;
            st_q  <= ST_CMD;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_CMD: begin
          if (tx_done) st_q <= ST_ADDR;
        end
        ST_ADDR: begin
          if (tx_done) begin
            if (idx_q == 2'd0) st_q <= ST_DATA;
            else               idx_q <= idx_q - 2'd1;
          end
        end
        ST_DATA: begin
          if (tx_done) begin
            addr_q <= addr_q + 1'b1;
            rem_q  <= rem_q - 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == (PW+1)'(1)) begin
              cs_q   <= 1'b1;
              busy_q <= BUSY_PROG;
              if (rem_q == LEN_W'(1)) begin
                done_q <= 1'b1;
                st_q   <= ST_IDLE;
              end else begin
                st_q   <= ST_WAIT;
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign busy_code_o = busy_q;
  assign done_o      = done_q;
  assign spi_cs_no   = cs_q;
endmodule

// File: rtl/fpe_checker.sv
module fpe_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ready_o,
  input logic       wready_o,
  input logic [1:0] busy_code_o,
  input logic       done_o,
  input logic       spi_sclk_o,
  input logic       spi_cs_no,
  input logic       spi_mosi_o
);
  p_cs_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_cs_no) |-> (busy_code_o == 2'd0));

  p_busy_mark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((busy_code_o == 2'd1) && ($past(busy_code_o) == 2'd0)) |-> $rose(spi_cs_no));

  p_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wready_o |-> !spi_cs_no);

  p_mode0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sclk_o |-> (!spi_cs_no && $stable(spi_mosi_o)));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (spi_cs_no && !spi_sclk_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_cs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> spi_cs_no);
endmodule

bind flash_prog_engine fpe_checker u_chk (.*);

// File: tb/tb_flash_prog_engine.sv
module tb_flash_prog_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        addr4 = 1'b0;
  logic [7:0]  wdata = '0;
  logic        wvalid = 1'b0;
  logic        wready;
  logic [1:0]  busy_code;
  logic        poll_done = 1'b0;
  logic        done;
  logic        sclk, cs_n, mosi;

  always #2.5 clk = ~clk;

  flash_prog_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .addr4_i(addr4),
    .wdata_i(wdata), .wvalid_i(wvalid), .wready_o(wready),
    .busy_code_o(busy_code), .poll_done_i(poll_done), .done_o(done),
    .spi_sclk_o(sclk), .spi_cs_no(cs_n), .spi_mosi_o(mosi)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // SPI monitor
  logic [7:0] got_q[$];
  int         flen_q[$];
  logic [7:0] shv = '0;
  int bitc = 0, fbytes = 0, cs_falls = 0, busy_viol = 0, partial = 0;

  always @(posedge sclk) if (!cs_n) begin
    shv = {shv[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      got_q.push_back(shv);
      bitc = 0;
      fbytes++;
    end
  end
  always @(negedge cs_n) if (rst_n) begin
    cs_falls++;
    if (busy_code != 2'd0) busy_viol++;
    fbytes = 0;
    bitc = 0;
  end
  always @(posedge cs_n) if (rst_n) begin
    flen_q.push_back(fbytes);
    if (bitc != 0) partial++;
  end

  // stream feeder
  int feed_cnt = 0, feed_base = 0, feed_len = 0, cyc = 0, seed = 0;
  bit feed_en = 1'b0;
  always @(posedge clk) if (wvalid && wready) feed_cnt <= feed_cnt + 1;

  function automatic logic [7:0] dbyte(input int k, input int s);
    return 8'((k * 37 + s * 11 + 5) & 255);
  endfunction

  initial forever begin
    @(negedge clk);
    cyc++;
    wvalid = feed_en && ((feed_cnt - feed_base) < feed_len) &&
             (((feed_cnt + cyc) % 4) != 3);
    wdata  = dbyte(feed_cnt - feed_base, seed);
  end

  // busy poller model, stall observer
  int plat = 1, pcnt = 0, marks = 0, nab = 3, wr_viol = 0;
  logic [1:0] prev_busy = 2'd0;
  initial forever begin
    @(negedge clk);
    if (busy_code == 2'd1 && prev_busy == 2'd0) marks++;
    prev_busy = busy_code;
    if (busy_code == 2'd1) begin
      if (pcnt >= plat) begin poll_done = 1'b1; pcnt = 0; end
      else begin poll_done = 1'b0; pcnt++; end
    end else begin
      poll_done = 1'b0;
      pcnt = 0;
    end
    if (wready && (cs_n || fbytes < 1 + nab)) wr_viol++;
  end

  task automatic run_req(input logic [31:0] a0, input int len, input bit a4, input int lat);
    logic [7:0] exp_b[$];
    int exp_fl[$];
    logic [31:0] a;
    int rem, k, c, nchunk, off, falls0;
    bit got_done, ok;
    string tag;
    a = a0; rem = len; k = 0; nchunk = 0;
    nab = a4 ? 4 : 3;
    while (rem > 0) begin
      c = 256 - int'(a[7:0]);
      if (rem < c) c = rem;
      exp_b.push_back(8'h06); exp_fl.push_back(1);
      exp_b.push_back(8'h02);
      if (a4) exp_b.push_back(a[31:24]);
      exp_b.push_back(a[23:16]); exp_b.push_back(a[15:8]); exp_b.push_back(a[7:0]);
      for (int j = 0; j < c; j++) exp_b.push_back(dbyte(k + j, seed));
      exp_fl.push_back(1 + nab + c);
      a += 32'(c); rem -= c; k += c; nchunk++;
    end
    got_q.delete(); flen_q.delete();
    marks = 0; wr_viol = 0; busy_viol = 0; partial = 0; plat = lat;
    falls0 = cs_falls;
    feed_base = feed_cnt; feed_len = len; feed_en = 1'b1;
    req_addr = a0; req_len = 16'(len); addr4 = a4; req_valid = 1'b1;
    @(negedge clk);
    got_done = done;
    req_valid = 1'b0;
    if (len == 0) begin
      chk(got_done, "R7", "done in cycle after zero-length accept", got_done, 1);
    end
    for (int t = 0; t < 20000 && !got_done; t++) begin
      @(negedge clk);
      got_done = done;
    end
    chk(got_done, "R9", "done pulse seen", got_done, 1);
    @(negedge clk);
    chk(!done, "R9", "done single cycle", done, 0);
    chk(cs_n, "R9", "cs high at done", cs_n, 1);
    repeat (4) @(negedge clk);
    feed_en = 1'b0;
    if (len == 0) begin
      chk(cs_falls == falls0, "R7", "no cs activity", cs_falls - falls0, 0);
      chk(feed_cnt == feed_base, "R7", "no stream byte taken", feed_cnt - feed_base, 0);
      return;
    end
    chk(flen_q.size() == exp_fl.size(), "R6", "frame count", flen_q.size(), exp_fl.size());
    chk(feed_cnt - feed_base == len, "R6", "bytes consumed", feed_cnt - feed_base, len);
    chk(marks == nchunk, "R5", "busy marks per chunk", marks, nchunk);
    chk(busy_viol == 0, "R5", "cs fell while busy", busy_viol, 0);
    chk(wr_viol == 0, "R8", "wready outside data phase", wr_viol, 0);
    chk(partial == 0, "R4", "frame closed mid-byte", partial, 0);
    off = 0;
    for (int f = 0; f < exp_fl.size() && f < flen_q.size(); f++) begin
      chk(flen_q[f] == exp_fl[f], "R1", $sformatf("frame %0d length", f), flen_q[f], exp_fl[f]);
      tag = (f % 2 == 0) ? "R2" : "R3/R4";
      ok = 1'b1;
      for (int b = 0; b < exp_fl[f]; b++) begin
        if (off + b >= got_q.size() || off + b >= exp_b.size()) begin ok = 1'b0; break; end
        if (got_q[off + b] !== exp_b[off + b]) begin
          chk(1'b0, tag, $sformatf("frame %0d byte %0d", f, b), got_q[off + b], exp_b[off + b]);
          ok = 1'b0;
          break;
        end
      end
      if (ok) chk(1'b1, tag, "frame content", 0, 0);
      off += exp_fl[f];
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int offs[4] = '{0, 1, 200, 255};
    int lens[6] = '{1, 2, 255, 256, 257, 300};
    bit a4;
    logic [31:0] base;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs_n == 1'b1, "R11", "cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R11", "sclk", sclk, 0);
    chk(busy_code == 2'd0, "R11", "busy_code", busy_code, 0);
    chk(done == 1'b0 && wready == 1'b0, "R11", "done/wready", {done, wready}, 0);
    chk(req_ready == 1'b1, "R11", "req_ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    run_req(32'h0000_1234, 0, 1'b0, 1);
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 6; j++) begin
        a4   = ((i + j) % 2) == 1;
        base = a4 ? 32'h01A3_4500 : 32'h5577_2300;
        seed = i * 6 + j;
        run_req(base | 32'(offs[i]), lens[j], a4, (i * 3 + j) % 7);
      end
    end
    run_req(32'h0000_00FF, 0, 1'b1, 2);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule